// File: doc/BRIEF.md
# DAC Sample-and-Hold Clock Sequencer

This block produces the clock that periodically refreshes the charge on a DAC sample-and-hold capacitor. It also reports which phase the refresh is in. A prescaler divides the input clock into a base tick. A sample-clock period is a whole number of base ticks. In an active period the output is high for a coded number of ticks and then low for a coded number of ticks. In an inactive period the output stays low for the same total length.

After an enable, the block first runs a setup burst of back-to-back active periods, which charges the capacitor quickly. It then moves to a sparse hold refresh. In the hold phase a programmed number of inactive periods comes before each active period, and this pattern repeats for as long as the block is enabled. Dropping the enable never cuts a period short. The period in progress runs to its end, and only then does the clock park low and both status flags clear. The configuration is latched when a sequence starts, so software may rewrite it while the block is running.

Top module: `sampclk_seq`

## Requirements
- R1: One base tick lasts `cfgDiv`+1 input clock cycles (divide by 1 to 64 for the default 6-bit field).
- R2: `cfgHighSel` sets the high time of an active period: 0 gives 2 base ticks and 1 gives 4 base ticks. The high part comes first in the period.
- R3: `cfgLowSel` values 0, 1, 2 and 3 give a low time of 1, 2, 3 and 4 base ticks, which follows the high part of an active period.
- R4: Suppose `enable` is sampled high while the block is idle. Starting in the next cycle, the block runs `cfgSetupCnt`+1 consecutive active periods. During these periods `setupActive` is 1 and `holdActive` is 0.
- R5: After the setup burst, `holdActive` is 1 and `setupActive` is 0. The hold phase repeats a group of `cfgHoldGap` inactive periods, with `smplClk` low, followed by one active period, for as long as the block is enabled. Every period, inactive or active, lasts (high+low) base ticks.
- R6: If `enable` is low at the last cycle of a period, then from the next cycle on `smplClk`, `setupActive` and `holdActive` are all 0. A period that is in progress is never shortened.
- R7: If `enable` is cleared and then raised again before the current period ends, the sequence carries on unchanged and does not restart. A new sequence starts only from idle.
- R8: Changes to the configuration inputs while a sequence runs have no effect on that sequence. The configuration is captured in the cycle the sequence starts.
- R9: While reset is active, and after reset with `enable` low, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Sequence enable, a level |
| cfgDiv | input | 6 | Prescaler code, base tick = cfgDiv+1 cycles |
| cfgHighSel | input | 1 | High-time code (0: 2 ticks, 1: 4 ticks) |
| cfgLowSel | input | 2 | Low-time code (n: n+1 ticks) |
| cfgSetupCnt | input | 4 | Setup burst length minus one, in periods |
| cfgHoldGap | input | 8 | Inactive periods before each hold refresh |
| smplClk | output | 1 | Sample clock to the DAC |
| setupActive | output | 1 | Setup burst in progress |
| holdActive | output | 1 | Hold phase in progress |

## Verification
The assertions assume that `enable` and the configuration inputs are synchronous to `clk` and settle before each rising edge. They also assume that reset is applied once before the first sequence. The bench meets these assumptions by driving every input on the falling edge and sampling the outputs on that same falling edge. For each scenario, the bench works out the expected waveform cycle by cycle from the decoded lengths. It moves `enable` and the configuration mid-run only at known cycle offsets, so the stop boundary and the ignored rewrite fall at positions it can predict.

// File: rtl/sampclk_pkg.sv
package sampclk_pkg;
  // strobes from the phase controller into the timing datapath
  typedef struct packed {
    logic load;   // capture configuration and clear counters
    logic run;    // advance prescaler and period counters
  } dpStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2
  } phase_t;
endpackage

// File: rtl/sampclk_datapath.sv
module sampclk_datapath
  import sampclk_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgHighSel,
  input  logic [1:0]       cfgLowSel,
  output logic             periodEnd,
  output logic             highPhase
);
  localparam int LEN_W = 4;  // high (<=4) + low (<=4) ticks

  logic [DIV_W-1:0] divR, divCnt;
  logic [LEN_W-1:0] hiLen, perLen, baseCnt;
  logic tick;

  assign tick      = strb.run && (divCnt == divR);
  assign periodEnd = tick && (baseCnt == perLen - LEN_W'(1));
  assign highPhase = baseCnt < hiLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divR    <= '0;
      hiLen   <= LEN_W'(2);
      perLen  <= LEN_W'(3);
      divCnt  <= '0;
      baseCnt <= '0;
    end else if (strb.load) begin
      divR    <= cfgDiv;
      hiLen   <= cfgHighSel ? LEN_W'(4) : LEN_W'(2);
      perLen  <= (cfgHighSel ? LEN_W'(4) : LEN_W'(2)) + LEN_W'(cfgLowSel) + LEN_W'(1);
      divCnt  <= '0;
      baseCnt <= '0;
    end else if (strb.run) begin
      if (tick) begin
        divCnt  <= '0;
        baseCnt <= periodEnd ? '0 : baseCnt + LEN_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  p_div_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (divCnt <= divR));
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> (baseCnt < perLen));
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.load) |=> ($stable(perLen) && $stable(hiLen) && $stable(divR)));
endmodule

// File: rtl/sampclk_ctrl.sv
module sampclk_ctrl
  import sampclk_pkg::*;
#(
  parameter int SETUP_W = 4,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [SETUP_W-1:0] cfgSetupCnt,
  input  logic [GAP_W-1:0]   cfgHoldGap,
  input  logic               periodEnd,
  input  logic               highPhase,
  output dpStrobe_t          strb,
  output logic               smplClk,
  output logic               setupActive,
  output logic               holdActive
);
  localparam int IDX_W = (GAP_W > SETUP_W) ? GAP_W : SETUP_W;

  phase_t           phase;
  logic [IDX_W-1:0] perIdx, setupLast, gapR;
  logic             activePeriod;

  assign strb.load    = (phase == PH_IDLE) && enable;
  assign strb.run     = (phase != PH_IDLE);
  assign activePeriod = (phase == PH_SETUP) || ((phase == PH_HOLD) && (perIdx == gapR));
  assign smplClk      = activePeriod && highPhase;
  assign setupActive  = (phase == PH_SETUP);
  assign holdActive   = (phase == PH_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      perIdx    <= '0;
      setupLast <= '0;
      gapR      <= '0;
    end else if (strb.load) begin
      phase     <= PH_SETUP;
      perIdx    <= '0;
      setupLast <= IDX_W'(cfgSetupCnt);
      gapR      <= IDX_W'(cfgHoldGap);
    end else if (periodEnd) begin
      if (!enable) begin
        phase  <= PH_IDLE;
        perIdx <= '0;
      end else if (phase == PH_SETUP) begin
        if (perIdx == setupLast) begin
          phase  <= PH_HOLD;
          perIdx <= '0;
        end else begin
          perIdx <= perIdx + IDX_W'(1);
        end
      end else begin
        perIdx <= (perIdx == gapR) ? '0 : perIdx + IDX_W'(1);
      end
    end
  end

  p_status_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(setupActive && holdActive));
  p_setup_to_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (setupActive && periodEnd && enable && perIdx == setupLast) |=> (holdActive && !setupActive));
  p_no_early_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !periodEnd) |=> strb.run);
  p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && periodEnd && !enable) |=> (!smplClk && !setupActive && !holdActive));
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |-> !strb.load);
endmodule

// File: rtl/sampclk_seq.sv
module sampclk_seq #(
  parameter int DIV_W   = 6,
  parameter int SETUP_W = 4,
  parameter int GAP_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic               cfgHighSel,
  input  logic [1:0]         cfgLowSel,
  input  logic [SETUP_W-1:0] cfgSetupCnt,
  input  logic [GAP_W-1:0]   cfgHoldGap,
  output logic               smplClk,
  output logic               setupActive,
  output logic               holdActive
);
  import sampclk_pkg::*;

  dpStrobe_t strb;
  logic      periodEnd, highPhase;

  sampclk_ctrl #(.SETUP_W(SETUP_W), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgSetupCnt(cfgSetupCnt), .cfgHoldGap(cfgHoldGap),
    .periodEnd(periodEnd), .highPhase(highPhase),
    .strb(strb), .smplClk(smplClk),
    .setupActive(setupActive), .holdActive(holdActive)
  );

  sampclk_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgDiv(cfgDiv), .cfgHighSel(cfgHighSel), .cfgLowSel(cfgLowSel),
    .periodEnd(periodEnd), .highPhase(highPhase)
  );

  p_quiet_in_reset_r9: assert property (@(posedge clk)
    !rstN |-> (!smplClk && !setupActive && !holdActive));
endmodule

// File: tb/sampclk_seq_test.sv
module sampclk_seq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [5:0] cfgDiv = '0;
  logic       cfgHighSel = 1'b0;
  logic [1:0] cfgLowSel = '0;
  logic [3:0] cfgSetupCnt = '0;
  logic [7:0] cfgHoldGap = '0;
  logic       smplClk, setupActive, holdActive;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sampclk_seq uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgDiv(cfgDiv), .cfgHighSel(cfgHighSel), .cfgLowSel(cfgLowSel),
    .cfgSetupCnt(cfgSetupCnt), .cfgHoldGap(cfgHoldGap),
    .smplClk(smplClk), .setupActive(setupActive), .holdActive(holdActive)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // Run one sequence and compare every cycle against the waveform computed
  // from the decoded lengths. stopAt / reraiseAt: cycle after whose sample
  // enable is dropped / raised again (-1: never). scramble rewrites the config.
  task automatic runSeq(input string req, input int d, input int h, input int l,
                        input int s, input int g, input int nCyc,
                        input int stopAt, input int reraiseAt, input bit scramble);
    int dd = d + 1;
    int hiT = (h != 0) ? 4 : 2;
    int loT = l + 1;
    int per = (hiT + loT) * dd;
    int nSet = s + 1;
    int bound = -1;
    @(negedge clk);
    cfgDiv = 6'(d); cfgHighSel = h[0]; cfgLowSel = 2'(l);
    cfgSetupCnt = 4'(s); cfgHoldGap = 8'(g);
    enable = 1'b1;
    if (stopAt >= 0) begin
      bound = (stopAt / per + 1) * per;
      if (reraiseAt >= 0 && reraiseAt < bound) bound = -1;  // R7: stop cancelled
    end
    for (int c = 0; c < nCyc; c++) begin
      int p, w, eClk, eSet, eHold;
      bit act;
      @(negedge clk);
      p = c / per;
      w = c % per;
      act = (p < nSet) || (((p - nSet) % (g + 1)) == g);
      eClk  = (act && (w < hiT * dd)) ? 1 : 0;
      eSet  = (p < nSet) ? 1 : 0;
      eHold = (p < nSet) ? 0 : 1;
      if (bound >= 0 && c >= bound) begin
        eClk = 0; eSet = 0; eHold = 0;
        check("R6", "smplClk", int'(smplClk), eClk);
        check("R6", "status", int'({setupActive, holdActive}), 0);
      end else begin
        check(req, "smplClk", int'(smplClk), eClk);
        check((p < nSet) ? "R4" : "R5", "setupActive", int'(setupActive), eSet);
        check((p < nSet) ? "R4" : "R5", "holdActive", int'(holdActive), eHold);
      end
      if (c == stopAt) enable = 1'b0;
      if (c == reraiseAt) enable = 1'b1;
      if (scramble && c == 3) begin  // R8: mid-run rewrite must be ignored
        cfgDiv = 6'(d + 5); cfgHighSel = ~h[0]; cfgLowSel = 2'(l + 2);
        cfgSetupCnt = 4'(s + 7); cfgHoldGap = 8'(g + 9);
      end
    end
    enable = 1'b0;
    for (int k = 0; k < 1200 && (setupActive || holdActive); k++) @(negedge clk);
    check("R6", "idle after stop", int'({smplClk, setupActive, holdActive}), 0);
  endtask

  task automatic testReset();
    #1;
    check("R9", "outputs in reset", int'({smplClk, setupActive, holdActive}), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R9", "outputs idle", int'({smplClk, setupActive, holdActive}), 0);
    end
  endtask

  initial begin
    testReset();
    runSeq("R2", 0, 0, 0, 1, 0,   40, -1, -1, 1'b0);  // shortest lengths
    runSeq("R1", 3, 1, 3, 0, 2,  256, -1, -1, 1'b0);  // prescaler 4
    runSeq("R5", 1, 0, 1, 2, 3,  160, -1, -1, 1'b0);  // hold gaps
    runSeq("R3", 0, 1, 2, 3, 1,  100, -1, -1, 1'b0);  // low code 2
    runSeq("R6", 2, 0, 0, 15, 0,  80, 40, -1, 1'b0);  // stop mid-period
    runSeq("R7", 1, 1, 0, 0, 1,   80, 23, 26, 1'b0);  // drop and re-raise
    runSeq("R8", 2, 0, 3, 1, 2,  150, -1, -1, 1'b1);  // config rewrite
    runSeq("R1", 63, 1, 3, 0, 0, 1100, -1, -1, 1'b0); // divide by 64
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule